// File: doc/BRIEF.md
# Type B Command Frame Receiver

This block takes the reader-to-card bit stream of a contactless Type B link after envelope detection and slicing, and turns it into bytes. The line is offered as one binary sample per strobe on `smp_en`, four samples per bit period. Samples taken while the strobe is low are ignored, so the block can run on a fast clock while the line rate stays low.

A frame opens with a long low phase followed by a rise. The receiver measures that low phase in whole bits and rejects it if it is too short or too long. Each character after that is ten bits: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Every good character is delivered as a one-cycle strobe with its byte and a running byte count. A character in which all ten bits are low closes the frame. A long high gap between characters, an overlong start-of-frame low phase, or a broken character produces an error pulse. After an error the receiver waits for the line to go high again before it looks for a new frame.

The receiver makes each bit decision on a single sample near the middle of the bit. It uses no filtering and no majority vote.

Top module: `tbr_frame_rx`

## Requirements
- R1: While reset is asserted and just after it is released, `byte_vld`, `frame_done` and `err` are low and `byte_cnt` is 0.
- R2: A start of frame is accepted when 10, 11 or 12 consecutive low bits are followed by a high bit. Acceptance clears `byte_cnt` to 0.
- R3: A low phase of fewer than 10 bits followed by a high bit is discarded without an error. The characters that follow it produce no output.
- R4: When the start-of-frame low phase reaches a 13th low bit, `err` pulses and no frame opens.
- R5: A character (start bit low, data bit 0 first through bit 7, stop bit high) yields one `byte_vld` pulse with the byte on `byte_data`. On that same cycle `byte_cnt` goes up by one.
- R6: Between characters, the line may stay high for at most 25 samples counted from the sample after the stop-bit decision. The 26th high sample pulses `err`.
- R7: A character whose ten bits are all low pulses `frame_done` and produces no byte. `byte_cnt` keeps the frame's byte count until the next start of frame.
- R8: A character with a low stop bit that is not all low pulses `err` and produces no byte.
- R9: After `err`, the receiver ignores the line until it has been high for four consecutive samples. It then receives the next frame normally.
- R10: `byte_cnt` stops at 256. Characters beyond the 256th produce no `byte_vld`, and `frame_done` still reports 256.
- R11: Only samples with `smp_en` high are used. Noise on `rx_bit` in other cycles has no effect. Every output pulse appears in the cycle after a strobed sample.
- R12: A start of frame needs a falling edge: a low sample that follows a high sample. A line that is low from reset onward opens no frame and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_en | input | 1 | Sample strobe, four per bit period |
| rx_bit | input | 1 | Demodulated line level, valid when `smp_en` is high |
| byte_vld | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte, valid with `byte_vld` |
| byte_cnt | output | 9 | Bytes received in the current frame, saturating at 256 |
| frame_done | output | 1 | One-cycle pulse on the end-of-frame character |
| err | output | 1 | One-cycle pulse when a timing or framing rule is broken |

## Verification
A wrong sample-position count shifts the mid-bit decision. The first wrong bit then shows up within one character, as a wrong `byte_data` value or as a spurious `err`. A wrong bit count, or an off-by-one in the start-of-frame or gap limits, shows at the ports within the same frame. The bench walks those limits on both sides: 9, 10, 12 and 13 low bits, and 24 versus 25 extra idle samples. A count that fails to clear or to saturate shows in `byte_cnt` at the next byte or at `frame_done`.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF_LOW,
    ST_WAIT_START,
    ST_DATA,
    ST_ERR_WAIT
  } tbr_state_e;

  function automatic int tbr_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tbr_rst_sync.sv
module tbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/tbr_run_ctr.sv
module tbr_run_ctr #(
  parameter int W    = 4,
  parameter int MAXV = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_inc
);

  localparam logic [W-1:0] LIM = W'(MAXV);

  logic [W-1:0] cnt_d;

  // Saturating increment value, offered to the controller for look-ahead.
  assign cnt_inc = (cnt >= LIM) ? LIM : cnt + 1'b1;

  always_comb begin
    cnt_d = cnt;
    if (en) begin
      if (clr)      cnt_d = '0;
      else if (inc) cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/tbr_char_shift.sv
module tbr_char_shift #(
  parameter int CHAR_BITS = 10,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 clr,
  input  logic                 shift,
  input  logic                 din,
  output logic [DATA_BITS-1:0] data,
  output logic                 frame_ok,
  output logic                 is_eof
);

  logic [CHAR_BITS-1:0] sr_q;
  logic [CHAR_BITS-1:0] sr_shift;
  logic [CHAR_BITS-1:0] sr_d;

  // The newest bit enters at the top, so the start bit ends up in bit 0.
  assign sr_shift = {din, sr_q[CHAR_BITS-1:1]};
  assign data     = sr_shift[DATA_BITS:1];
  assign frame_ok = sr_shift[CHAR_BITS-1] & ~sr_shift[0];
  assign is_eof   = ~|sr_shift;

  always_comb begin
    sr_d = sr_q;
    if (en) begin
      if (clr)        sr_d = '0;
      else if (shift) sr_d = sr_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

endmodule

// File: rtl/tbr_frame_rx.sv
module tbr_frame_rx #(
  parameter int SPB       = 4,
  parameter int MID       = 2,
  parameter int SOF_MIN   = 10,
  parameter int SOF_MAX   = 12,
  parameter int GAP_LIMIT = 25,
  parameter int CHAR_BITS = 10,
  parameter int DATA_BITS = 8,
  parameter int MAX_BYTES = 256,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_en,
  input  logic                 rx_bit,
  output logic                 byte_vld,
  output logic [DATA_BITS-1:0] byte_data,
  output logic [CNT_W-1:0]     byte_cnt,
  output logic                 frame_done,
  output logic                 err
);
  import tbr_pkg::*;

  localparam int POS_MAXV = GAP_LIMIT + 1;
  localparam int POS_W    = $clog2(POS_MAXV + 1);
  localparam int BIT_MAXV = tbr_max(SOF_MAX + 1, CHAR_BITS);
  localparam int BIT_W    = $clog2(BIT_MAXV + 1);

  localparam logic [POS_W-1:0] P_MID = POS_W'(MID);
  localparam logic [POS_W-1:0] P_SPB = POS_W'(SPB);
  localparam logic [POS_W-1:0] P_GAP = POS_W'(GAP_LIMIT);
  localparam logic [BIT_W-1:0] B_MIN = BIT_W'(SOF_MIN);
  localparam logic [BIT_W-1:0] B_MAX = BIT_W'(SOF_MAX);
  localparam logic [BIT_W-1:0] B_CHR = BIT_W'(CHAR_BITS);

  logic rst_n_s;

  tbr_state_e st_q, st_d;
  logic       last_rx_q;

  logic             pos_clr, pos_inc;
  logic [POS_W-1:0] pos_cnt, pos_nxt;
  logic             bit_clr, bit_inc;
  logic [BIT_W-1:0] bit_cnt, bit_nxt;
  logic             cnt_clr, cnt_inc;
  logic [CNT_W-1:0] cnt_nxt;
  logic             sh_clr, sh_shift;

  logic [DATA_BITS-1:0] chr_data;
  logic                 chr_ok, chr_eof;
  logic                 vld_d, done_d, err_d;

  tbr_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // Sample position inside a bit; also measures idle gaps and error recovery.
  tbr_run_ctr #(.W(POS_W), .MAXV(POS_MAXV)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (smp_en),
    .clr     (pos_clr),
    .inc     (pos_inc),
    .cnt     (pos_cnt),
    .cnt_inc (pos_nxt)
  );

  // Bit count: low bits of the start phase, then bits of a character.
  tbr_run_ctr #(.W(BIT_W), .MAXV(BIT_MAXV)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (smp_en),
    .clr     (bit_clr),
    .inc     (bit_inc),
    .cnt     (bit_cnt),
    .cnt_inc (bit_nxt)
  );

  // Byte count of the current frame, saturating at MAX_BYTES.
  tbr_run_ctr #(.W(CNT_W), .MAXV(MAX_BYTES)) u_bytes (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (smp_en),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .cnt     (byte_cnt),
    .cnt_inc (cnt_nxt)
  );

  tbr_char_shift #(.CHAR_BITS(CHAR_BITS), .DATA_BITS(DATA_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .en       (smp_en),
    .clr      (sh_clr),
    .shift    (sh_shift),
    .din      (rx_bit),
    .data     (chr_data),
    .frame_ok (chr_ok),
    .is_eof   (chr_eof)
  );

  always_comb begin
    st_d     = st_q;
    pos_clr  = 1'b0;
    pos_inc  = 1'b0;
    bit_clr  = 1'b0;
    bit_inc  = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    sh_clr   = 1'b0;
    sh_shift = 1'b0;
    vld_d    = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!rx_bit && last_rx_q) begin
          st_d    = ST_SOF_LOW;
          pos_clr = 1'b1;
          bit_clr = 1'b1;
        end
      end
      ST_SOF_LOW: begin
        pos_inc = 1'b1;
        if (pos_nxt == P_SPB) pos_clr = 1'b1;
        if (pos_nxt == P_MID) begin
          if (rx_bit) begin
            if (bit_cnt >= B_MIN) begin
              st_d    = ST_WAIT_START;
              pos_clr = 1'b1;
              cnt_clr = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end else begin
            bit_inc = 1'b1;
            if (bit_nxt > B_MAX) begin
              st_d    = ST_ERR_WAIT;
              err_d   = 1'b1;
              pos_clr = 1'b1;
            end
          end
        end
      end
      ST_WAIT_START: begin
        if (rx_bit) begin
          pos_inc = 1'b1;
          if (pos_cnt >= P_GAP) begin
            st_d    = ST_ERR_WAIT;
            err_d   = 1'b1;
            pos_clr = 1'b1;
          end
        end else begin
          st_d    = ST_DATA;
          pos_clr = 1'b1;
          bit_clr = 1'b1;
          sh_clr  = 1'b1;
        end
      end
      ST_DATA: begin
        pos_inc = 1'b1;
        if (pos_nxt == P_SPB) pos_clr = 1'b1;
        if (pos_nxt == P_MID) begin
          sh_shift = 1'b1;
          bit_inc  = 1'b1;
          if (bit_nxt == B_CHR) begin
            if (chr_ok) begin
              st_d    = ST_WAIT_START;
              pos_clr = 1'b1;
              if (cnt_nxt != byte_cnt) begin
                vld_d   = 1'b1;
                cnt_inc = 1'b1;
              end
            end else if (chr_eof) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else begin
              st_d    = ST_ERR_WAIT;
              err_d   = 1'b1;
              pos_clr = 1'b1;
            end
          end
        end
      end
      ST_ERR_WAIT: begin
        if (rx_bit) begin
          pos_inc = 1'b1;
          if (pos_nxt >= P_SPB) st_d = ST_IDLE;
        end else begin
          pos_clr = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q      <= ST_IDLE;
      last_rx_q <= 1'b0;
    end else if (smp_en) begin
      st_q      <= st_d;
      last_rx_q <= rx_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      byte_vld   <= 1'b0;
      frame_done <= 1'b0;
      err        <= 1'b0;
    end else begin
      byte_vld   <= smp_en & vld_d;
      frame_done <= smp_en & done_d;
      err        <= smp_en & err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)             byte_data <= '0;
    else if (smp_en && vld_d) byte_data <= chr_data;
  end

endmodule

// File: rtl/tbr_frame_rx_chk.sv
module tbr_frame_rx_chk #(
  parameter int CNT_W     = 9,
  parameter int MAX_BYTES = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_en,
  input logic             byte_vld,
  input logic             frame_done,
  input logic             err,
  input logic [CNT_W-1:0] byte_cnt
);

  localparam logic [CNT_W-1:0] CMAX = CNT_W'(MAX_BYTES);

  a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> byte_cnt == CNT_W'($past(byte_cnt) + 1'b1));

  a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_vld, frame_done, err}));

  a_r7_done_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $stable(byte_cnt));

  a_r2_cnt_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !$stable(byte_cnt)) |-> byte_cnt == '0);

  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CMAX);

  a_r11_strobe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_en) |-> !(byte_vld || frame_done || err));

endmodule

bind tbr_frame_rx tbr_frame_rx_chk #(
  .CNT_W     (CNT_W),
  .MAX_BYTES (MAX_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_en     (smp_en),
  .byte_vld   (byte_vld),
  .frame_done (frame_done),
  .err        (err),
  .byte_cnt   (byte_cnt)
);

// File: tb/tbr_frame_rx_test.sv
module tbr_frame_rx_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, smp_en, rx_bit;
  logic       byte_vld, frame_done, err;
  logic [7:0] byte_data;
  logic [8:0] byte_cnt;

  tbr_frame_rx uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (smp_en),
    .rx_bit     (rx_bit),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .byte_cnt   (byte_cnt),
    .frame_done (frame_done),
    .err        (err)
  );

  typedef struct {
    int    kind;   // 0 byte, 1 frame done, 2 error
    int    data;
    int    cnt;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0, n_evt = 0, cyc = 0;
  int   stride = 2;
  bit   noise = 0;
  logic en_at_edge = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic push(input int kind, input int data, input int cnt, input string req);
    exp_t e;
    e.kind = kind; e.data = data; e.cnt = cnt; e.req = req;
    q.push_back(e);
  endtask

  always @(posedge clk) en_at_edge <= smp_en;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R5", "watchdog cycles", cyc, 150000);
      summary();
      $finish;
    end
  end

  // Monitor: pops the scoreboard on every output event.
  always @(negedge clk) begin
    int   kind;
    exp_t e;
    if (rst_n && (byte_vld || frame_done || err)) begin
      n_evt++;
      kind = byte_vld ? 0 : (frame_done ? 1 : 2);
      chk(en_at_edge === 1'b1, "R11", "event after strobe", int'(en_at_edge), 1);
      if (q.size() == 0) begin
        chk(0, "R3", "unexpected event kind", kind, -1);
      end else begin
        e = q.pop_front();
        chk(kind == e.kind, e.req, "event kind", kind, e.kind);
        if (kind == e.kind && kind == 0)
          chk(int'(byte_data) == e.data, e.req, "byte value", int'(byte_data), e.data);
        if (kind == e.kind && kind != 2)
          chk(int'(byte_cnt) == e.cnt, e.req, "byte count", int'(byte_cnt), e.cnt);
      end
    end
  end

  task automatic smp(input logic b);
    @(negedge clk);
    smp_en = 1'b1;
    rx_bit = b;
    for (int i = 1; i < stride; i++) begin
      @(negedge clk);
      smp_en = 1'b0;
      rx_bit = noise ? 1'($urandom_range(0, 1)) : b;
    end
  endtask

  task automatic tbit(input logic b);
    repeat (4) smp(b);
  endtask

  task automatic sof(input int nz, input int nh);
    repeat (nz) tbit(1'b0);
    repeat (nh) tbit(1'b1);
  endtask

  task automatic chr(input logic [7:0] d, input logic stop);
    tbit(1'b0);
    for (int i = 0; i < 8; i++) tbit(d[i]);
    tbit(stop);
  endtask

  task automatic eof();
    repeat (10) tbit(1'b0);
    repeat (2) tbit(1'b1);
  endtask

  task automatic idle(input int n);
    repeat (n) smp(1'b1);
  endtask

  initial begin
    int base;
    rst_n = 1'b0; smp_en = 1'b0; rx_bit = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(byte_vld == 1'b0,   "R1", "byte_vld in reset", int'(byte_vld), 0);
    chk(frame_done == 1'b0, "R1", "frame_done in reset", int'(frame_done), 0);
    chk(err == 1'b0,        "R1", "err in reset", int'(err), 0);
    chk(byte_cnt == 9'd0,   "R1", "byte_cnt in reset", int'(byte_cnt), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(byte_cnt == 9'd0 && !err, "R1", "outputs after release", int'(byte_cnt), 0);

    // R12: line low from reset, 15 bit periods, then high
    base = n_evt;
    repeat (60) smp(1'b0);
    idle(8);
    repeat (3) @(negedge clk);
    chk(n_evt == base, "R12", "events with no falling edge", n_evt - base, 0);

    // R2 R5 R7: minimum start phase, three bytes incl. 0x00 and 0xFF
    push(0, 8'h05, 1, "R5"); push(0, 8'h00, 2, "R5"); push(0, 8'hFF, 3, "R5");
    push(1, 0, 3, "R7");
    sof(10, 2); chr(8'h05, 1'b1); chr(8'h00, 1'b1); chr(8'hFF, 1'b1); eof();

    // R2: longest legal low phase, count cleared at new frame
    push(0, 8'hA5, 1, "R2"); push(1, 0, 1, "R2");
    sof(12, 3); chr(8'hA5, 1'b1); eof();

    // R4: 13 low bits
    push(2, 0, 0, "R4");
    sof(13, 2); idle(8);

    // R9: normal frame right after the error
    push(0, 8'h3C, 1, "R9"); push(1, 0, 1, "R9");
    sof(11, 2); chr(8'h3C, 1'b1); eof();

    // R3: short low phase, following character ignored
    base = n_evt;
    sof(9, 2); chr(8'h5A, 1'b1); idle(12);
    repeat (3) @(negedge clk);
    chk(n_evt == base, "R3", "events after short start", n_evt - base, 0);

    // R6: 24 extra idle samples accepted between characters
    push(0, 8'h11, 1, "R6"); push(0, 8'h22, 2, "R6"); push(1, 0, 2, "R6");
    sof(10, 2); chr(8'h11, 1'b1); idle(24); chr(8'h22, 1'b1); eof();

    // R6: 25 extra idle samples is an error
    push(0, 8'h33, 1, "R6"); push(2, 0, 0, "R6");
    sof(10, 2); chr(8'h33, 1'b1); idle(25); idle(8);

    // R8: bad stop bit
    push(2, 0, 0, "R8");
    sof(10, 2); chr(8'h81, 1'b0); idle(12);

    // R11: sparse strobe with noise in between
    stride = 3; noise = 1;
    push(0, 8'hC3, 1, "R11"); push(0, 8'h7E, 2, "R11"); push(1, 0, 2, "R11");
    sof(10, 2); chr(8'hC3, 1'b1); chr(8'h7E, 1'b1); eof();
    stride = 2; noise = 0;

    // R10: 258 characters, the last two dropped
    for (int i = 0; i < 256; i++) push(0, i & 8'hFF, i + 1, "R10");
    push(1, 0, 256, "R10");
    sof(10, 2);
    for (int i = 0; i < 258; i++) chr(8'(i), 1'b1);
    eof();

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R7", "expected events left over", q.size(), 0);
    summary();
    $finish;
  end

endmodule